// File: doc/BRIEF.md
# Lookahead Adder/Subtractor with Signed Overflow

This block adds or subtracts two N-bit two's-complement words. A single mode input selects the operation. When subtracting, every bit of the second operand is inverted and the carry into bit 0 is forced to 1, which forms the two's complement. No carry ripples through single bits. Each 4-bit slice forms its generate and propagate terms in parallel. It then computes all four of its carries from those terms and its own carry-in. Carries pass only from one slice to the next.

The block returns the N-bit result, the carry out of the top bit, and a signed overflow flag. The flag is the exclusive-OR of the carry out of the top bit and the carry into the top bit. An optional output register captures all three results on a clock edge where the valid input is high. The register then holds them until the next valid cycle. A delayed valid output goes with the registered results. With the register disabled, the outputs follow the inputs combinationally.

Top module: `la_addsub`

## Requirements
- R1: With sub_mode = 0, result equals (op_x + op_y) modulo 2^N.
- R2: With sub_mode = 1, result equals (op_x − op_y) modulo 2^N.
- R3: In add mode, carry_out is the unsigned carry out of bit N−1. In subtract mode, carry_out is 1 exactly when op_x ≥ op_y as unsigned numbers, so subtracting zero always gives carry_out = 1.
- R4: ovf is 1 exactly when the true signed sum or difference lies outside [−2^(N−1), 2^(N−1)−1]. This covers operands equal to the most negative value. Adding operands of opposite sign never overflows. Subtracting operands of equal sign never overflows.
- R5: With the output register present (REGISTER_OUT = 1), result, carry_out and ovf change on the first rising edge where valid_in = 1. They keep their values across edges where valid_in = 0, whatever the operands and mode do.
- R6: A rising edge with rst_n = 0 clears result, carry_out, ovf and valid_out to 0.
- R7: valid_out equals the valid_in seen at the previous rising edge outside reset.
- R8: N must be a multiple of 4. Each 4-bit slice forms its carries only from its generate terms, its propagate terms and its own carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Capture strobe for the output register |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| op_x | input | N | First operand |
| op_y | input | N | Second operand |
| result | output | N | Sum or difference, modulo 2^N |
| carry_out | output | 1 | Carry out of the top bit |
| ovf | output | 1 | Signed overflow |
| valid_out | output | 1 | Marks results captured at the previous edge |

## Verification
Overflow in subtract mode is the hardest case to reach. This is especially true when the second operand is the most negative value: inverting it and adding 1 carries through every slice, so the carry into the top bit and the carry out of it must come from different lookahead paths. Random operands almost never land there. The bench therefore applies directed pairs built from the most negative value, minus one, zero and the largest positive value in both modes. A separate task drives a carry through all slices, using all-ones plus one and zero minus one. Random pairs then cover the general case.

// File: rtl/addsub_pkg.sv
// Package: shared constants for the lookahead adder/subtractor.
// Assumes: operand width is a whole number of lookahead slices.
package addsub_pkg;
    localparam int SLICE_W = 4;   // bits covered by one lookahead slice
endpackage

// File: rtl/addsub_operand.sv
// Module: addsub_operand
// Prepares the second operand and the initial carry for the selected mode.
// Assumes: sub_mode is a static level during the cycle; purely combinational.
module addsub_operand #(
    parameter int N = 16
) (
    input  logic         sub_mode,
    input  logic [N-1:0] y_in,
    output logic [N-1:0] y_eff,
    output logic         c_init
);
    // Invert every bit for subtraction and force carry-in to form -Y.
    always_comb begin
        y_eff  = y_in ^ {N{sub_mode}};
        c_init = sub_mode;
    end
endmodule

// File: rtl/cla_slice4.sv
// Module: cla_slice4
// One 4-bit carry-lookahead slice: all carries come from G/P terms and cin.
// Assumes: inputs are settled; purely combinational, two-level carry logic.
module cla_slice4 (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       cout
);
    logic [3:0] g;
    logic [3:0] p;
    logic [3:0] c;

    // Form all generate and propagate terms in parallel.
    always_comb begin
        g = a & b;
        p = a ^ b;
    end

    // Expanded carries: each depends only on g, p and cin.
    always_comb begin
        c[0] = cin;
        c[1] = g[0] | (p[0] & cin);
        c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
        c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
             | (p[2] & p[1] & p[0] & cin);
        cout = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
             | (p[3] & p[2] & p[1] & g[0]) | (p[3] & p[2] & p[1] & p[0] & cin);
    end

    // Sum bits from propagate and the incoming carry of each bit.
    always_comb sum = p ^ c;
endmodule

// File: rtl/la_addsub.sv
// Module: la_addsub (top)
// N-bit add/subtract built from chained 4-bit lookahead slices, with signed
// overflow from the top two carries and an optional valid-gated output register.
// Assumes: N is a multiple of 4; reset is synchronous and active low.
module la_addsub #(
    parameter int N            = 16,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic         sub_mode,
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    output logic [N-1:0] result,
    output logic         carry_out,
    output logic         ovf,
    output logic         valid_out
);
    import addsub_pkg::*;

    localparam int SLICES = N / SLICE_W;

    // R8: width must split into whole slices.
    initial begin
        if (N % SLICE_W != 0 || N < SLICE_W)
            $error("la_addsub: N must be a positive multiple of 4 (R8)");
    end

    logic [N-1:0]    y_eff;
    logic [SLICES:0] chain;
    logic [N-1:0]    sum_c;
    logic            c_msb_in;
    logic            ovf_c;

    addsub_operand #(.N(N)) u_operand (
        .sub_mode (sub_mode),
        .y_in     (op_y),
        .y_eff    (y_eff),
        .c_init   (chain[0])
    );

    // One lookahead slice per 4 bits; only the slice carries are chained.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        cla_slice4 u_slice (
            .a    (op_x[s*SLICE_W +: SLICE_W]),
            .b    (y_eff[s*SLICE_W +: SLICE_W]),
            .cin  (chain[s]),
            .sum  (sum_c[s*SLICE_W +: SLICE_W]),
            .cout (chain[s+1])
        );
    end

    // Carry into the top bit recovered from its sum bit, then overflow flag.
    always_comb begin
        c_msb_in = sum_c[N-1] ^ op_x[N-1] ^ y_eff[N-1];
        ovf_c    = chain[SLICES] ^ c_msb_in;
    end

    if (REGISTER_OUT) begin : g_reg
        // Capture results on valid cycles; clear everything in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                carry_out <= 1'b0;
                ovf       <= 1'b0;
                valid_out <= 1'b0;
            end else begin
                valid_out <= valid_in;
                if (valid_in) begin
                    result    <= sum_c;
                    carry_out <= chain[SLICES];
                    ovf       <= ovf_c;
                end
            end
        end

        p_reset_clear_r6: assert property (@(posedge clk)
            !rst_n |=> (result == '0 && !carry_out && !ovf && !valid_out));

        p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in |=> valid_out);

        p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_in |=> ($stable(result) && $stable(carry_out) && $stable(ovf)));

        p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && ((!sub_mode && (op_x[N-1] != op_y[N-1])) ||
                          ( sub_mode && (op_x[N-1] == op_y[N-1])))) |=> !ovf);

        p_sub_zero_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && sub_mode && op_y == '0) |=> (carry_out && result == $past(op_x)));
    end else begin : g_comb
        // Outputs follow the arithmetic directly; valid passes through.
        always_comb begin
            result    = sum_c;
            carry_out = chain[SLICES];
            ovf       = ovf_c;
            valid_out = valid_in & rst_n;
        end
    end
endmodule

// File: tb/la_addsub_test.sv
module la_addsub_test;
    localparam int N = 16;
    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] MAXV = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] ONES = {N{1'b1}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic         sub_mode = 1'b0;
    logic [N-1:0] op_x = '0;
    logic [N-1:0] op_y = '0;
    logic [N-1:0] result;
    logic         carry_out, ovf, valid_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    la_addsub #(.N(N), .REGISTER_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .sub_mode(sub_mode),
        .op_x(op_x), .op_y(op_y), .result(result), .carry_out(carry_out),
        .ovf(ovf), .valid_out(valid_out)
    );

    task automatic check(input string tag, input logic [N+2:0] act, input logic [N+2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent reference from integer arithmetic.
    task automatic ref_model(input logic [N-1:0] x, input logic [N-1:0] y, input logic sub,
                             output logic [N-1:0] r, output logic co, output logic of);
        longint sx, sy, sres;
        longint ux, uy;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        ux = longint'(x);
        uy = longint'(y);
        if (sub) begin
            sres = sx - sy;
            r    = N'(ux - uy);
            co   = (ux >= uy);
        end else begin
            sres = sx + sy;
            r    = N'(ux + uy);
            co   = ((ux + uy) >> N) != 0;
        end
        of = (sres > longint'(2**(N-1) - 1)) || (sres < -longint'(2**(N-1)));
    endtask

    // Apply one operation at a falling edge, sample one cycle later.
    task automatic run_op(input string tag, input logic [N-1:0] x, input logic [N-1:0] y, input logic sub);
        logic [N-1:0] er;
        logic eco, eof;
        @(negedge clk);
        op_x = x; op_y = y; sub_mode = sub; valid_in = 1'b1;
        @(negedge clk);
        ref_model(x, y, sub, er, eco, eof);
        check({tag, (sub ? " R2 result" : " R1 result")}, {3'b0, result}, {3'b0, er});
        check({tag, " R3 carry"}, {{(N+2){1'b0}}, carry_out}, {{(N+2){1'b0}}, eco});
        check({tag, " R4 ovf"}, {{(N+2){1'b0}}, ovf}, {{(N+2){1'b0}}, eof});
        check({tag, " R7 valid_out"}, {{(N+2){1'b0}}, valid_out}, {{(N+2){1'b0}}, 1'b1});
    endtask

    task automatic test_reset;
        rst_n = 1'b0; valid_in = 1'b1; op_x = 16'h1234; op_y = 16'h1111;
        repeat (3) @(negedge clk);
        check("R6 reset result", {3'b0, result}, '0);
        check("R6 reset flags", {{N{1'b0}}, carry_out, ovf, valid_out}, '0);
        valid_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 idle valid_out", {{(N+2){1'b0}}, valid_out}, '0);
    endtask

    task automatic test_add;
        run_op("add small", 16'h0003, 16'h0004, 1'b0);
        run_op("add pos ovf", MAXV, 16'h0001, 1'b0);
        run_op("add neg ovf", MINV, ONES, 1'b0);
        run_op("add mixed", MAXV, MINV, 1'b0);
        run_op("add full carry", ONES, 16'h0001, 1'b0);
        run_op("add R8 slice edge", 16'h0FFF, 16'h0001, 1'b0);
    endtask

    task automatic test_sub;
        run_op("sub small", 16'h0009, 16'h0004, 1'b0 | 1'b1);
        run_op("sub borrow", 16'h0000, 16'h0001, 1'b1);
        run_op("sub zero R3", 16'h8765, 16'h0000, 1'b1);
        run_op("sub equal", 16'h4242, 16'h4242, 1'b1);
    endtask

    task automatic test_min_value;
        run_op("0-MIN", 16'h0000, MINV, 1'b1);
        run_op("MIN-1", MINV, 16'h0001, 1'b1);
        run_op("MIN-MIN", MINV, MINV, 1'b1);
        run_op("-1-MIN", ONES, MINV, 1'b1);
        run_op("MAX-(-1)", MAXV, ONES, 1'b1);
        run_op("MIN+MIN", MINV, MINV, 1'b0);
    endtask

    task automatic test_hold;
        logic [N-1:0] er;
        logic eco, eof;
        run_op("pre-hold", 16'h7000, 16'h1000, 1'b0);
        ref_model(16'h7000, 16'h1000, 1'b0, er, eco, eof);
        @(negedge clk);
        valid_in = 1'b0; op_x = 16'h0001; op_y = 16'h0002; sub_mode = 1'b1;
        @(negedge clk);
        op_x = MINV; op_y = 16'h0001;
        @(negedge clk);
        check("R5 hold result", {3'b0, result}, {3'b0, er});
        check("R5 hold flags", {{N{1'b0}}, carry_out, ovf, valid_out},
              {{N{1'b0}}, eco, eof, 1'b0});
    endtask

    task automatic test_random;
        for (int i = 0; i < 300; i++) begin
            logic [N-1:0] x, y;
            logic s;
            x = N'($urandom);
            y = N'($urandom);
            s = 1'($urandom);
            run_op("random", x, y, s);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        test_reset;
        test_add;
        test_sub;
        test_min_value;
        test_hold;
        test_random;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule